// File: doc/BRIEF.md
# Full-Duplex Serial Port with Double-Buffered Receiver

This block is a byte-wide serial port of the kind found beside a small 8-bit controller core. Software sees two register addresses. One holds mode, receive enable, the ninth bits and the two completion flags. The other is a data address. A write to the data address starts a transmission. A read from the same address returns a separate receive holding register. The receiver assembles each byte in its own shift register and copies it to the holding register only when the previous byte has been taken. A new frame can therefore arrive while software is still reading the last one.

There are four modes. Mode 0 is a synchronous shifter: eight bits go out or come in LSB first, data travels on the bidirectional data pin and a shift clock is driven on the transmit pin. Mode 1 sends 10-bit frames. Modes 2 and 3 send 11-bit frames that carry a ninth data bit. Modes 1 and 3 take their bit timing from an external baud tick, which is normally a timer overflow. Mode 2 uses a fixed divide of the system clock. The asynchronous receiver takes 16 samples per bit and decides each bit by majority vote.

Top module: `serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the data address reads 0x00, `txd` is high, `rxd_oe` is low and both flags are low.
- R2: In mode 1 a write to the data address (`bus_sel`=1) sends a frame on `txd` made of a low start bit, the 8 data bits LSB first and a high stop bit. Each bit lasts 16 oversample ticks, and in mode 1 an oversample tick is one `baud_tick` pulse. The transmit flag (control bit 5) is set at the end of the stop bit and not before.
- R3: In modes 2 and 3 the transmitted frame has a ninth bit between data bit 7 and the stop bit, taken from control bit 3. In mode 2 an oversample tick is every DIV2_TICK clocks. In mode 3 it is `baud_tick`.
- R4: In mode 1, with receive enable (control bit 2) set, a received frame puts its byte in the holding register, copies its stop bit into control bit 4 and sets the receive flag (control bit 6).
- R5: In modes 2 and 3 the received ninth bit is stored into control bit 4.
- R6: Each asynchronous bit is the majority of three samples taken at oversample ticks 7, 8 and 9 of the bit, so a pulse shorter than one tick inside a bit does not change the received value.
- R7: If the start bit is high at mid-bit, reception is abandoned with no flag set, and the receiver accepts the next frame normally.
- R8: A new frame can be received while the receive flag is still set. The holding register keeps the earlier byte during that frame, and the new byte is loaded if software clears the flag before the frame ends.
- R9: A frame that completes while the receive flag is set is discarded, and the holding register and control bit 4 stay unchanged.
- R10: With receive enable clear, activity on `rxd_in` neither sets the receive flag nor changes the holding register.
- R11: In mode 0 a data write shifts the 8 bits out on `rxd_out`, LSB first, with `rxd_oe` high. `txd` is a shift clock that is low for M0_HALF clocks and then high for M0_HALF clocks, and each bit is valid at the rising edge. The transmit flag is set after the eighth bit.
- R12: In mode 0, writing the control register with receive enable 1 and receive flag 0 starts a receive of 8 clock periods on `txd`. `rxd_in` is sampled at each rising edge, LSB first, and then the holding register is loaded and the receive flag is set.
- R13: Transmit and receive run concurrently, so a mode 1 frame looped from `txd` back to `rxd_in` is sent and received at the same time.
- R14: Both flags stay set until software writes the control register with them cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register; control layout is {0, rx flag, tx flag, rx bit 9, tx bit 9, rx enable, mode[1:0]} |
| baud_tick | input | 1 | Oversample tick from a timer, used in modes 1 and 3 |
| rxd_in | input | 1 | Receive data pin |
| rxd_out | output | 1 | Data pin output value in mode 0 transmit |
| rxd_oe | output | 1 | Data pin output enable, high during mode 0 transmit |
| txd | output | 1 | Transmit line, or the shift clock in mode 0 |
| ti_irq | output | 1 | Transmit-done flag |
| ri_irq | output | 1 | Receive-done flag |

## Verification
The bench sweeps data patterns through every mode in both directions. It decodes `txd` at mid-bit with its own timing and builds receive frames from scratch, so a swapped bit order, a missing or misplaced ninth bit, or a wrong oversample rate shows up as a wrong bit. It injects a glitch inside a bit and a short false start. A receiver without majority voting would flip the glitched bit, and one without the start check would report a bogus byte. The double-buffer cases receive a second frame with the flag still set, once clearing the flag mid-frame and once not. An unbuffered design would lose the first byte early, and a design that ignores the flag would overwrite it. The bench also checks that the flags stay set over long idle periods and that mode 0 puts its clock and data on the correct pins.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        MD_SHIFT      = 2'd0,
        MD_ASYNC8     = 2'd1,
        MD_ASYNC9_FIX = 2'd2,
        MD_ASYNC9_TMR = 2'd3
    } sp_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_WAIT  = 2'd1,
        TX_ASYNC = 2'd2,
        TX_SHIFT = 2'd3
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_ASYNC  = 2'd1,
        RX_WAIT0  = 2'd2,
        RX_SHIFT0 = 2'd3
    } rx_st_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen
    import sp_pkg::*;
#(
    parameter int DIV2_TICK = 4,
    parameter int M0_HALF   = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sp_mode_e mode_i,
    input  logic     baud_tick_i,
    output logic     os_tick_o,
    output logic     half_tick_o
);
    localparam int DW = (DIV2_TICK > 1) ? $clog2(DIV2_TICK) : 1;
    localparam int HW = (M0_HALF > 1) ? $clog2(M0_HALF) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DIV2_TICK - 1);
    localparam logic [HW-1:0] HLAST = HW'(M0_HALF - 1);

    typedef struct packed {
        logic [DW-1:0] dcnt;
        logic [HW-1:0] hcnt;
    } tick_s;

    tick_s q, d;

    always_comb begin
        d = q;
        d.dcnt = (q.dcnt == DLAST) ? '0 : q.dcnt + 1'b1;
        d.hcnt = (q.hcnt == HLAST) ? '0 : q.hcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign os_tick_o   = (mode_i == MD_ASYNC9_FIX) ? (q.dcnt == DLAST) : baud_tick_i;
    assign half_tick_o = (q.hcnt == HLAST);

endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sp_mode_e   mode_i,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic       b9_i,
    input  logic       os_tick_i,
    input  logic       half_tick_i,
    output logic       line_o,
    output logic       m0_clk_o,
    output logic       m0_dat_o,
    output logic       m0_busy_o,
    output logic       done_o
);
    typedef struct packed {
        tx_st_e      st;
        logic [10:0] sh;
        logic [3:0]  bitn;
        logic [3:0]  last;
        logic [3:0]  tcnt;
        logic        ph;
        logic        m0;
    } tx_s;

    tx_s  q, d;
    logic done_c;

    always_comb begin
        d      = q;
        done_c = 1'b0;
        case (q.st)
            TX_WAIT: begin
                if (q.m0 ? half_tick_i : os_tick_i) begin
                    d.st   = q.m0 ? TX_SHIFT : TX_ASYNC;
                    d.tcnt = '0;
                    d.ph   = 1'b0;
                    d.bitn = '0;
                end
            end
            TX_ASYNC: begin
                if (os_tick_i) begin
                    if (q.tcnt == 4'd15) begin
                        d.tcnt = '0;
                        d.sh   = {1'b1, q.sh[10:1]};
                        if (q.bitn == q.last) begin
                            d.st   = TX_IDLE;
                            done_c = 1'b1;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            TX_SHIFT: begin
                if (half_tick_i) begin
                    if (!q.ph) begin
                        d.ph = 1'b1;
                    end else begin
                        d.ph = 1'b0;
                        d.sh = {1'b1, q.sh[10:1]};
                        if (q.bitn == 4'd7) begin
                            d.st   = TX_IDLE;
                            done_c = 1'b1;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase
        if (load_i) begin
            d.st   = TX_WAIT;
            d.m0   = (mode_i == MD_SHIFT);
            d.bitn = '0;
            d.tcnt = '0;
            d.ph   = 1'b0;
            if (mode_i == MD_SHIFT) begin
                d.sh   = {3'b111, data_i};
                d.last = 4'd7;
            end else if (mode_i == MD_ASYNC8) begin
                d.sh   = {2'b11, data_i, 1'b0};
                d.last = 4'd9;
            end else begin
                d.sh   = {1'b1, b9_i, data_i, 1'b0};
                d.last = 4'd10;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: TX_IDLE, sh: '1, default: '0};
        else        q <= d;
    end

    assign line_o    = (q.st == TX_ASYNC) ? q.sh[0] : 1'b1;
    assign m0_clk_o  = q.ph;
    assign m0_dat_o  = q.sh[0];
    assign m0_busy_o = (q.st == TX_SHIFT);
    assign done_o    = done_c;

    // R2: the start bit follows the first oversample tick after a load
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_WAIT && !q.m0 && os_tick_i && !load_i) |=> !line_o);

endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sp_mode_e   mode_i,
    input  logic       ren_i,
    input  logic       rxd_i,
    input  logic       os_tick_i,
    input  logic       half_tick_i,
    input  logic       m0_start_i,
    output logic       done_o,
    output logic [7:0] data_o,
    output logic       b9_o,
    output logic       m0_clk_o,
    output logic       m0_busy_o
);
    typedef struct packed {
        rx_st_e     st;
        logic [1:0] sync;
        logic [3:0] tcnt;
        logic [3:0] bitn;
        logic [1:0] smp;
        logic [7:0] sh;
        logic       b9;
        logic       ph;
        logic       done;
    } rx_s;

    rx_s  q, d;
    logic line, nine, vote;

    assign line = q.sync[1];
    assign nine = (mode_i != MD_ASYNC8);
    assign vote = maj3(q.smp[0], q.smp[1], line);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sync = {q.sync[0], rxd_i};
        case (q.st)
            RX_IDLE: begin
                if (mode_i != MD_SHIFT && os_tick_i && !line) begin
                    d.st   = RX_ASYNC;
                    d.tcnt = 4'd1;
                    d.bitn = '0;
                end
            end
            RX_ASYNC: begin
                if (os_tick_i) begin
                    if (q.tcnt == 4'd7) d.smp[0] = line;
                    if (q.tcnt == 4'd8) d.smp[1] = line;
                    if (q.tcnt == 4'd9) begin
                        if (q.bitn == 4'd0) begin
                            if (vote) d.st = RX_IDLE;
                        end else if (q.bitn <= 4'd8) begin
                            d.sh = {vote, q.sh[7:1]};
                        end else if (q.bitn == 4'd9 && nine) begin
                            d.b9 = vote;
                        end else begin
                            d.b9   = nine ? q.b9 : vote;
                            d.done = 1'b1;
                            d.st   = RX_IDLE;
                        end
                    end
                    if (q.tcnt == 4'd15) begin
                        d.tcnt = '0;
                        d.bitn = q.bitn + 1'b1;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            RX_WAIT0: begin
                if (half_tick_i) begin
                    d.st   = RX_SHIFT0;
                    d.ph   = 1'b0;
                    d.bitn = '0;
                end
            end
            RX_SHIFT0: begin
                if (half_tick_i) begin
                    if (!q.ph) begin
                        d.ph = 1'b1;
                        d.sh = {line, q.sh[7:1]};
                    end else begin
                        d.ph = 1'b0;
                        if (q.bitn == 4'd7) begin
                            d.done = 1'b1;
                            d.st   = RX_IDLE;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase
        if (!ren_i) d.st = RX_IDLE;
        if (m0_start_i) d.st = RX_WAIT0;
        d.done = d.done & ren_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: RX_IDLE, sync: 2'b11, default: '0};
        else        q <= d;
    end

    assign done_o    = q.done;
    assign data_o    = q.sh;
    assign b9_o      = q.b9;
    assign m0_clk_o  = q.ph;
    assign m0_busy_o = (q.st == RX_SHIFT0);

    // R10: with receive disabled, no frame completes
    p_rx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_i |=> !done_o);

endmodule

// File: rtl/serial_port.sv
module serial_port
    import sp_pkg::*;
#(
    parameter int DIV2_TICK = 4,
    parameter int M0_HALF   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       baud_tick,
    input  logic       rxd_in,
    output logic       rxd_out,
    output logic       rxd_oe,
    output logic       txd,
    output logic       ti_irq,
    output logic       ri_irq
);
    typedef struct packed {
        sp_mode_e   mode;
        logic       ren;
        logic       tb8;
        logic       rb8;
        logic       ti;
        logic       ri;
        logic [7:0] hold;
    } top_s;

    top_s q, d;

    logic       ctrl_wr, data_wr, m0_start;
    logic       os_tick, half_tick;
    logic       tx_line, tx_m0_clk, tx_m0_dat, tx_m0_busy, tx_done;
    logic       rx_done, rx_b9, rx_m0_clk, rx_m0_busy;
    logic [7:0] rx_data;

    assign ctrl_wr  = bus_we && !bus_sel;
    assign data_wr  = bus_we && bus_sel;
    assign m0_start = ctrl_wr && (bus_wdata[1:0] == 2'd0) && bus_wdata[2] && !bus_wdata[6];

    sp_tick_gen #(.DIV2_TICK(DIV2_TICK), .M0_HALF(M0_HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .mode_i(q.mode), .baud_tick_i(baud_tick),
        .os_tick_o(os_tick), .half_tick_o(half_tick)
    );

    sp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .mode_i(q.mode), .load_i(data_wr),
        .data_i(bus_wdata), .b9_i(q.tb8), .os_tick_i(os_tick), .half_tick_i(half_tick),
        .line_o(tx_line), .m0_clk_o(tx_m0_clk), .m0_dat_o(tx_m0_dat),
        .m0_busy_o(tx_m0_busy), .done_o(tx_done)
    );

    sp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .mode_i(q.mode), .ren_i(q.ren), .rxd_i(rxd_in),
        .os_tick_i(os_tick), .half_tick_i(half_tick), .m0_start_i(m0_start),
        .done_o(rx_done), .data_o(rx_data), .b9_o(rx_b9),
        .m0_clk_o(rx_m0_clk), .m0_busy_o(rx_m0_busy)
    );

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.mode = sp_mode_e'(bus_wdata[1:0]);
            d.ren  = bus_wdata[2];
            d.tb8  = bus_wdata[3];
            d.rb8  = bus_wdata[4];
            d.ti   = bus_wdata[5];
            d.ri   = bus_wdata[6];
        end
        if (tx_done) d.ti = 1'b1;
        if (rx_done && !d.ri) begin
            d.hold = rx_data;
            if (q.mode != MD_SHIFT) d.rb8 = rx_b9;
            d.ri = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{mode: MD_SHIFT, default: '0};
        else        q <= d;
    end

    assign bus_rdata = bus_sel ? q.hold
                               : {1'b0, q.ri, q.ti, q.rb8, q.tb8, q.ren, q.mode};
    assign txd     = tx_m0_busy ? tx_m0_clk : (rx_m0_busy ? rx_m0_clk : tx_line);
    assign rxd_out = tx_m0_dat;
    assign rxd_oe  = tx_m0_busy;
    assign ti_irq  = q.ti;
    assign ri_irq  = q.ri;

    // R14: flags clear only through a control write
    p_ti_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ti && !ctrl_wr) |=> q.ti);
    p_ri_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ri && !ctrl_wr) |=> q.ri);
    // R9: a pending byte is never overwritten
    p_hold_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ri && !ctrl_wr) |=> $stable(q.hold));
    // R2: transmitter completion raises the transmit flag
    p_txdone_ti_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> q.ti);
    // R4: a completed frame with the flag clear is captured
    p_rxload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !q.ri && !ctrl_wr) |=> (q.ri && q.hold == $past(rx_data)));

endmodule

// File: tb/tb_serial_port.sv
`timescale 1ns/1ps
module tb_serial_port;
    localparam int DIV2 = 4;
    localparam int M0H  = 4;
    localparam int TICKP = 3;
    localparam int BITT = 16 * TICKP;
    localparam int BIT2 = 16 * DIV2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       baud_tick = 1'b0;
    logic       rxd_drv = 1'b1, loop = 1'b0;
    logic       rxd_in, rxd_out, rxd_oe, txd, ti_irq, ri_irq;
    int         checks = 0, failures = 0;

    assign rxd_in = loop ? txd : rxd_drv;

    serial_port #(.DIV2_TICK(DIV2), .M0_HALF(M0H)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
        .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd),
        .ti_irq(ti_irq), .ri_irq(ri_irq)
    );

    always #10 clk = ~clk;

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            baud_tick = (cnt == TICKP - 1);
            cnt = (cnt == TICKP - 1) ? 0 : cnt + 1;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] v);
        @(negedge clk);
        bus_sel = s; bus_we = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        bus_sel = s;
        #1 v = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] dv, input logic b9, input logic nine,
                        input int bt, input int gbit);
        rxd_drv = 1'b0; wait_clk(bt);
        for (int i = 0; i < 8; i++) begin
            rxd_drv = dv[i];
            if (gbit == i) begin
                wait_clk(bt/2 - 1); rxd_drv = ~dv[i];
                wait_clk(2);        rxd_drv = dv[i];
                wait_clk(bt - bt/2 - 1);
            end else wait_clk(bt);
        end
        if (nine) begin rxd_drv = b9; wait_clk(bt); end
        rxd_drv = 1'b1; wait_clk(bt);
    endtask

    task automatic tx_check(input logic [1:0] md, input logic [7:0] dv, input logic b9);
        int bt = (md == 2'd2) ? BIT2 : BITT;
        string rq = (md == 2'd1) ? "R2" : "R3";
        wr(1'b0, {4'b0000, b9, 1'b0, md});
        wr(1'b1, dv);
        while (txd !== 1'b0) @(negedge clk);
        wait_clk(bt/2);
        chk({rq, " start"}, txd, 1'b0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(bt);
            chk({rq, " data"}, txd, dv[i]);
        end
        if (md != 2'd1) begin
            wait_clk(bt);
            chk("R3 ninth", txd, b9);
        end
        wait_clk(bt);
        chk({rq, " stop"}, txd, 1'b1);
        chk("R2 ti late", ti_irq, 1'b0);
        wait_clk(bt/2 + 4);
        chk("R2 ti set", ti_irq, 1'b1);
    endtask

    task automatic rx_check(input logic [1:0] md, input logic [7:0] dv, input logic b9,
                            input int gbit, input string rq);
        logic [7:0] v;
        int bt = (md == 2'd2) ? BIT2 : BITT;
        wr(1'b0, {5'b00000, 1'b1, md});
        send(dv, b9, md != 2'd1, bt, gbit);
        wait_clk(4);
        chk({rq, " ri"}, ri_irq, 1'b1);
        rd(1'b1, v); chk({rq, " byte"}, v, dv);
        rd(1'b0, v); chk({rq, " rb8"}, v[4], (md == 2'd1) ? 1'b1 : b9);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] pats [7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 data", v, 8'h00);
        chk("R1 txd", txd, 1'b1);
        chk("R1 oe", rxd_oe, 1'b0);
        chk("R1 flags", {ti_irq, ri_irq}, 2'b00);

        // R2, R3 transmit sweep
        for (int m = 1; m < 4; m++)
            for (int k = 0; k < 7; k++)
                tx_check(2'(m), pats[k], k[0]);

        // R14 flag persists
        wait_clk(300);
        chk("R14 ti held", ti_irq, 1'b1);
        wr(1'b0, 8'h01);
        chk("R14 ti clear", ti_irq, 1'b0);

        // R4, R5 receive sweep
        for (int m = 1; m < 4; m++)
            for (int k = 0; k < 7; k++)
                rx_check(2'(m), pats[k], ^pats[k], -1, (m == 1) ? "R4" : "R5");
        wait_clk(300);
        chk("R14 ri held", ri_irq, 1'b1);

        // R6 majority vote against glitches
        rx_check(2'd1, 8'h96, 1'b0, 3, "R6");
        rx_check(2'd1, 8'h69, 1'b0, 6, "R6");

        // R7 false start
        wr(1'b0, 8'h05);
        rxd_drv = 1'b0; wait_clk(12); rxd_drv = 1'b1;
        wait_clk(3 * BITT);
        chk("R7 no ri", ri_irq, 1'b0);
        rx_check(2'd1, 8'hC7, 1'b0, -1, "R7");

        // R8 double buffer
        rx_check(2'd1, 8'h4E, 1'b0, -1, "R8");
        fork
            send(8'hB1, 1'b0, 1'b0, BITT, -1);
            begin
                wait_clk(5 * BITT);
                rd(1'b1, v); chk("R8 old kept", v, 8'h4E);
                wr(1'b0, 8'h05);
            end
        join
        wait_clk(4);
        rd(1'b1, v); chk("R8 new byte", v, 8'hB1);
        chk("R8 ri", ri_irq, 1'b1);

        // R9 overrun drop, with rb8 preset 0 to expose change
        wr(1'b0, 8'h45);
        send(8'h27, 1'b0, 1'b0, BITT, -1);
        wait_clk(4);
        rd(1'b1, v); chk("R9 hold kept", v, 8'hB1);
        rd(1'b0, v); chk("R9 rb8 kept", v[4], 1'b0);

        // R10 receive disabled
        wr(1'b0, 8'h01);
        send(8'h11, 1'b0, 1'b0, BITT, -1);
        wait_clk(4);
        chk("R10 no ri", ri_irq, 1'b0);
        rd(1'b1, v); chk("R10 hold", v, 8'hB1);

        // R13 full duplex loopback
        wr(1'b0, 8'h05);
        loop = 1'b1;
        wr(1'b1, 8'hC3);
        wait_clk(12 * BITT);
        loop = 1'b0;
        rd(1'b1, v); chk("R13 byte", v, 8'hC3);
        chk("R13 flags", {ti_irq, ri_irq}, 2'b11);

        // R11 mode 0 transmit
        for (int k = 2; k < 4; k++) begin
            wr(1'b0, 8'h00);
            wr(1'b1, pats[k]);
            for (int i = 0; i < 8; i++) begin
                @(posedge txd); #2;
                chk("R11 oe", rxd_oe, 1'b1);
                chk("R11 bit", rxd_out, pats[k][i]);
            end
            wait_clk(2 * M0H + 3);
            chk("R11 ti", ti_irq, 1'b1);
            chk("R11 idle", {txd, rxd_oe}, 2'b10);
        end

        // R12 mode 0 receive
        for (int k = 2; k < 4; k++) begin
            wr(1'b0, 8'h04);
            for (int i = 0; i < 8; i++) begin
                @(negedge txd);
                rxd_drv = pats[k][i];
            end
            wait_clk(2 * M0H + 4);
            rxd_drv = 1'b1;
            chk("R12 ri", ri_irq, 1'b1);
            rd(1'b1, v); chk("R12 byte", v, pats[k]);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule